// File: doc/BRIEF.md
# Measurement Window Monitor

This block keeps the latest reading of each measurement channel next to an 8-bit low limit and an 8-bit high limit. When an external converter presents a 10-bit result for a channel, the block keeps its upper eight bits as the channel's reading. It compares that value against the channel's window and, if the value falls outside, sets a sticky status bit for the channel.

A per-channel mask decides which status bits may drive the alert request sent to the bus interface. Masked channels still record their status. A read of the status register returns the recorded bits. The same read then releases only those bits whose channel has come back into range. A channel that is still out of range keeps its bit, so the alert stays up.

Software reaches the limits, readings, status and mask through a simple register port with one-cycle read latency.

Top module: `meas_window_monitor`

## Requirements
- R1: After reset every reading is 0x00, every low limit is 0x00, every high limit is 0xFF, and the status and mask registers are 0. The alert output is low.
- R2: When conv_valid is high, the reading register of channel conv_chan takes conv_data[9:2] at the clock edge. A nominal 10-bit code of 0x300 therefore reads back as 0xC0.
- R3: A reading strictly above its channel's high limit, or strictly below its low limit, sets bit i of the status register for channel i at the same edge that stores the reading.
- R4: A reading equal to either limit is in range and sets no status bit.
- R5: alert is high while any status bit is set whose mask bit is 0. Mask bit i at 1 keeps channel i out of the alert but does not stop its status bit from being set.
- R6: A status bit stays set across later in-range readings until the status register is read.
- R7: A status read returns the bits held before the read. At that edge it clears each bit whose channel's latest reading was in range and keeps each bit whose channel's latest reading was out of range.
- R8: A limit write never re-compares the stored reading. Only the next reading of that channel is checked against the new limit.
- R9: Register map, with N channels: reading i at address i, low limit i at N+i, high limit i at 2N+i, status at 3N, mask at 3N+1. Reading and status addresses are read-only and writes to them are ignored. reg_rdata shows the addressed register one cycle after reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_valid | input | 1 | Converter result strobe |
| conv_chan | input | 2 | Channel of the converter result |
| conv_data | input | 10 | Converter result code |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, one cycle after reg_rd |
| alert | output | 1 | Alert request to the bus interface |

## Verification
The properties assume that conv_chan always names an existing channel whenever conv_valid is high. They also assume that reg_wr and reg_rd are never raised together.

They check the set rule by indexing the limits with conv_chan. For that reason, the stimulus only ever sends channel numbers below the channel count. Each register task drives a single strobe for a single cycle, and every stimulus is applied at the falling edge.

// File: rtl/mw_pkg.sv
// Package for the measurement window monitor.
// Holds the register width and the helpers that lay out the register map.
// Assumes no more than eight channels, so status and mask fit in one register.
package mw_pkg;
    localparam int REG_W = 8;

    // Number of address bits needed for the register map of n channels
    function automatic int addr_bits(input int n);
        return $clog2(3 * n + 2);
    endfunction
endpackage

// File: rtl/mw_channel.sv
// One channel: reading register, window limits, and the out-of-window flag.
// Takes the upper REG_W bits of the converter code as its reading.
// Assumes sample_en is asserted for at most one channel at a time.
module mw_channel #(
    parameter int CONV_W = 10,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic [CONV_W-1:0] sample_code,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  reading,
    output logic [REG_W-1:0]  lo_lim,
    output logic [REG_W-1:0]  hi_lim,
    output logic              out_now,
    output logic              violation
);
    logic [REG_W-1:0] sample_val;
    logic             outside;

    // Compare the incoming sample against the present window (strict bounds)
    always_comb begin
        sample_val = sample_code[CONV_W-1 -: REG_W];
        outside    = (sample_val > hi_lim) || (sample_val < lo_lim);
        violation  = sample_en && outside;
    end

    // Hold the latest reading and whether it fell outside the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reading <= '0;
            out_now <= 1'b0;
        end else if (sample_en) begin
            reading <= sample_val;
            out_now <= outside;
        end
    end

    // Store the limits written by software; no retroactive compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_lim <= '0;
            hi_lim <= '1;
        end else begin
            if (lo_we) lo_lim <= wdata;
            if (hi_we) hi_lim <= wdata;
        end
    end
endmodule

// File: rtl/mw_status.sv
// Sticky status bits, alert mask, and alert request.
// A status read keeps bits whose channel is still out of range and drops the rest.
// A violation arriving in the same cycle as the read is always kept.
module mw_status #(
    parameter int NUM_CH = 4,
    parameter int REG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] violation,
    input  logic [NUM_CH-1:0] out_now,
    input  logic              stat_rd,
    input  logic              mask_we,
    input  logic [REG_W-1:0]  wdata,
    output logic [NUM_CH-1:0] status,
    output logic [NUM_CH-1:0] mask,
    output logic              alert
);
    logic [NUM_CH-1:0] kept;

    // Bits carried into the next cycle before the new violations are added
    always_comb kept = stat_rd ? (status & out_now) : status;

    // Update the sticky status register
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= kept | violation;
    end

    // Update the alert mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= wdata[NUM_CH-1:0];
    end

    // Raise the alert for any unmasked status bit
    always_comb alert = |(status & ~mask);
endmodule

// File: rtl/mw_regport.sv
// Register port: decodes the address into write enables and registers the read data.
// Map: readings at 0..N-1, low limits at N.., high limits at 2N.., status at 3N, mask at 3N+1.
// Assumes reg_wr and reg_rd are never asserted together.
module mw_regport #(
    parameter int NUM_CH = 4,
    parameter int REG_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic                         reg_rd,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [NUM_CH-1:0][REG_W-1:0] rd_all,
    input  logic [NUM_CH-1:0][REG_W-1:0] lo_all,
    input  logic [NUM_CH-1:0][REG_W-1:0] hi_all,
    input  logic [NUM_CH-1:0]            status,
    input  logic [NUM_CH-1:0]            mask,
    output logic [NUM_CH-1:0]            lo_we,
    output logic [NUM_CH-1:0]            hi_we,
    output logic                         mask_we,
    output logic                         stat_rd,
    output logic [REG_W-1:0]             rdata
);
    localparam int LO_BASE   = NUM_CH;
    localparam int HI_BASE   = 2 * NUM_CH;
    localparam int STAT_ADDR = 3 * NUM_CH;
    localparam int MASK_ADDR = 3 * NUM_CH + 1;

    logic [REG_W-1:0] rd_next;

    // Decode the write enables and the status read strobe
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            lo_we[i] = reg_wr && (reg_addr == ADDR_W'(LO_BASE + i));
            hi_we[i] = reg_wr && (reg_addr == ADDR_W'(HI_BASE + i));
        end
        mask_we = reg_wr && (reg_addr == ADDR_W'(MASK_ADDR));
        stat_rd = reg_rd && (reg_addr == ADDR_W'(STAT_ADDR));
    end

    // Select the addressed register for read-back
    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (reg_addr == ADDR_W'(i))           rd_next = rd_all[i];
            if (reg_addr == ADDR_W'(LO_BASE + i)) rd_next = lo_all[i];
            if (reg_addr == ADDR_W'(HI_BASE + i)) rd_next = hi_all[i];
        end
        if (reg_addr == ADDR_W'(STAT_ADDR)) rd_next = REG_W'(status);
        if (reg_addr == ADDR_W'(MASK_ADDR)) rd_next = REG_W'(mask);
    end

    // Register the read data one cycle after the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (reg_rd) rdata <= rd_next;
    end
endmodule

// File: rtl/meas_window_monitor.sv
// Top of the measurement window monitor.
// Holds one reading and a low/high limit pair per channel, records sticky
// out-of-window status, and raises a maskable alert.
// Assumes conv_chan names an existing channel whenever conv_valid is high.
module meas_window_monitor #(
    parameter int NUM_CH = 4,
    parameter int CONV_W = 10,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int ADDR_W = mw_pkg::addr_bits(NUM_CH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    conv_valid,
    input  logic [CH_W-1:0]         conv_chan,
    input  logic [CONV_W-1:0]       conv_data,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [mw_pkg::REG_W-1:0] reg_wdata,
    output logic [mw_pkg::REG_W-1:0] reg_rdata,
    output logic                    alert
);
    localparam int REG_W = mw_pkg::REG_W;

    logic [NUM_CH-1:0][REG_W-1:0] rd_all;
    logic [NUM_CH-1:0][REG_W-1:0] lo_all;
    logic [NUM_CH-1:0][REG_W-1:0] hi_all;
    logic [NUM_CH-1:0]            out_now;
    logic [NUM_CH-1:0]            violation;
    logic [NUM_CH-1:0]            lo_we;
    logic [NUM_CH-1:0]            hi_we;
    logic [NUM_CH-1:0]            stat_bits;
    logic [NUM_CH-1:0]            mask_bits;
    logic                         mask_we;
    logic                         stat_rd;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic sel;
        // Route the converter strobe to this channel
        always_comb sel = conv_valid && (conv_chan == CH_W'(g));

        mw_channel #(.CONV_W(CONV_W), .REG_W(REG_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .sample_en  (sel),
            .sample_code(conv_data),
            .lo_we      (lo_we[g]),
            .hi_we      (hi_we[g]),
            .wdata      (reg_wdata),
            .reading    (rd_all[g]),
            .lo_lim     (lo_all[g]),
            .hi_lim     (hi_all[g]),
            .out_now    (out_now[g]),
            .violation  (violation[g])
        );
    end

    mw_status #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .violation(violation),
        .out_now  (out_now),
        .stat_rd  (stat_rd),
        .mask_we  (mask_we),
        .wdata    (reg_wdata),
        .status   (stat_bits),
        .mask     (mask_bits),
        .alert    (alert)
    );

    mw_regport #(.NUM_CH(NUM_CH), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_wr  (reg_wr),
        .reg_rd  (reg_rd),
        .reg_addr(reg_addr),
        .rd_all  (rd_all),
        .lo_all  (lo_all),
        .hi_all  (hi_all),
        .status  (stat_bits),
        .mask    (mask_bits),
        .lo_we   (lo_we),
        .hi_we   (hi_we),
        .mask_we (mask_we),
        .stat_rd (stat_rd),
        .rdata   (reg_rdata)
    );
endmodule

// File: rtl/mw_window_checker.sv
// Property checker for the measurement window monitor, bound to the top.
// Assumes conv_chan is below NUM_CH whenever conv_valid is high.
module mw_window_checker #(
    parameter int NUM_CH = 4,
    parameter int CONV_W = 10,
    parameter int CH_W   = 2,
    parameter int ADDR_W = 4,
    parameter int REG_W  = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         conv_valid,
    input logic [CH_W-1:0]              conv_chan,
    input logic [CONV_W-1:0]            conv_data,
    input logic                         reg_wr,
    input logic                         reg_rd,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic                         alert,
    input logic [NUM_CH-1:0]            status,
    input logic [NUM_CH-1:0]            mask,
    input logic [NUM_CH-1:0][REG_W-1:0] rd_all,
    input logic [NUM_CH-1:0][REG_W-1:0] lo_all,
    input logic [NUM_CH-1:0][REG_W-1:0] hi_all
);
    logic [REG_W-1:0] top_bits;
    logic             st_read;
    logic             mk_write;

    // Derive the sample value and the control strobes for the properties
    always_comb begin
        top_bits = conv_data[CONV_W-1 -: REG_W];
        st_read  = reg_rd && (reg_addr == ADDR_W'(3 * NUM_CH));
        mk_write = reg_wr && (reg_addr == ADDR_W'(3 * NUM_CH + 1));
    end

    assert_set_above_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid && (top_bits > hi_all[conv_chan]) |=> status[$past(conv_chan)]);

    assert_set_below_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid && (top_bits < lo_all[conv_chan]) |=> status[$past(conv_chan)]);

    assert_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |=> rd_all[$past(conv_chan)] == $past(top_bits));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_read |=> ((status & $past(status)) == $past(status)));

    assert_alert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        alert && !st_read && !mk_write |=> alert);

    assert_reading_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && (reg_addr < ADDR_W'(NUM_CH)) && !conv_valid |=> $stable(rd_all));

    assert_limit_no_recheck_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_valid && !st_read |=> status == $past(status));
endmodule

bind meas_window_monitor mw_window_checker #(
    .NUM_CH(NUM_CH), .CONV_W(CONV_W), .CH_W(CH_W), .ADDR_W(ADDR_W), .REG_W(mw_pkg::REG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_valid(conv_valid),
    .conv_chan (conv_chan),
    .conv_data (conv_data),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .alert     (alert),
    .status    (stat_bits),
    .mask      (mask_bits),
    .rd_all    (rd_all),
    .lo_all    (lo_all),
    .hi_all    (hi_all)
);

// File: tb/meas_window_monitor_tb.sv
// Self-checking bench: vector table walk followed by directed corner tests.
module meas_window_monitor_tb;
    localparam int N    = 4;
    localparam int STAT = 3 * N;
    localparam int MSK  = 3 * N + 1;

    typedef struct packed {
        logic [1:0] ch;
        logic [9:0] code;
        logic [7:0] lo;
        logic [7:0] hi;
        logic       bad;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'd0, 10'h300, 8'h00, 8'hFF, 1'b0},
        '{2'd1, 10'h300, 8'h00, 8'hBF, 1'b1},
        '{2'd2, 10'h300, 8'h00, 8'hC0, 1'b0},
        '{2'd3, 10'h300, 8'hC0, 8'hFF, 1'b0},
        '{2'd0, 10'h2FC, 8'hC0, 8'hFF, 1'b1},
        '{2'd1, 10'h3FF, 8'h00, 8'hFE, 1'b1},
        '{2'd2, 10'h003, 8'h01, 8'hFF, 1'b1},
        '{2'd3, 10'h3FF, 8'h00, 8'hFF, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_valid = 1'b0;
    logic [1:0] conv_chan = '0;
    logic [9:0] conv_data = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       alert;
    int         errors = 0;
    int         checks = 0;
    logic [7:0] v;

    always #5 clk = ~clk;

    meas_window_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .conv_valid(conv_valid), .conv_chan(conv_chan),
        .conv_data(conv_data), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alert(alert)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 4'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic conv(input int ch, input logic [9:0] code);
        @(negedge clk);
        conv_valid = 1'b1; conv_chan = 2'(ch); conv_data = code;
        @(negedge clk);
        conv_valid = 1'b0;
    endtask

    // Return a channel to its default window and clear its status bit
    task automatic tidy(input int ch);
        logic [7:0] t;
        wr(N + ch, 8'h00);
        wr(2 * N + ch, 8'hFF);
        conv(ch, 10'h200);
        rd(STAT, t);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        check("R1 alert", {7'd0, alert}, 8'h00);
        rd(0, v);         check("R1 reading0", v, 8'h00);
        rd(N + 2, v);     check("R1 low2", v, 8'h00);
        rd(2 * N + 3, v); check("R1 high3", v, 8'hFF);
        rd(STAT, v);      check("R1 status", v, 8'h00);
        rd(MSK, v);       check("R1 mask", v, 8'h00);

        // R2 R3 R4: vector table walk
        foreach (VEC[k]) begin
            wr(N + int'(VEC[k].ch), VEC[k].lo);
            wr(2 * N + int'(VEC[k].ch), VEC[k].hi);
            conv(int'(VEC[k].ch), VEC[k].code);
            rd(int'(VEC[k].ch), v);
            check("R2 reading", v, VEC[k].code[9:2]);
            check("R5 alert", {7'd0, alert}, {7'd0, VEC[k].bad});
            rd(STAT, v);
            check(VEC[k].bad ? "R3 status" : "R4 status", v,
                  VEC[k].bad ? (8'h01 << VEC[k].ch) : 8'h00);
            tidy(int'(VEC[k].ch));
            rd(STAT, v);
            check("R7 cleared", v, 8'h00);
        end

        // R6 R7: sticky across in-range reading, then released by read
        wr(2 * N + 1, 8'h80);
        conv(1, 10'h300);
        conv(1, 10'h100);
        check("R6 alert held", {7'd0, alert}, 8'h01);
        rd(STAT, v); check("R6 status held", v, 8'h02);
        rd(STAT, v); check("R7 released", v, 8'h00);
        check("R7 alert low", {7'd0, alert}, 8'h00);
        tidy(1);

        // R7: still out of range keeps the bit across a read
        wr(2 * N + 2, 8'h80);
        conv(2, 10'h300);
        rd(STAT, v); check("R7 first read", v, 8'h04);
        rd(STAT, v); check("R7 still out", v, 8'h04);
        check("R7 alert kept", {7'd0, alert}, 8'h01);
        tidy(2);
        rd(STAT, v); check("R7 final clear", v, 8'h00);

        // R8: limit write does not re-compare the stored reading
        conv(0, 10'h300);
        wr(2 * N + 0, 8'h80);
        rd(STAT, v); check("R8 no recheck", v, 8'h00);
        check("R8 alert", {7'd0, alert}, 8'h00);
        conv(0, 10'h300);
        rd(STAT, v); check("R8 next reading", v, 8'h01);
        tidy(0);

        // R5: mask blocks the alert but not the status
        wr(MSK, 8'h08);
        rd(MSK, v); check("R9 mask readback", v, 8'h08);
        wr(2 * N + 3, 8'h10);
        conv(3, 10'h300);
        check("R5 masked alert", {7'd0, alert}, 8'h00);
        wr(MSK, 8'h00);
        check("R5 unmasked alert", {7'd0, alert}, 8'h01);
        rd(STAT, v); check("R5 masked status", v, 8'h08);
        tidy(3);

        // R9: read-only addresses ignore writes
        conv(1, 10'h0A4);
        wr(1, 8'h55);
        rd(1, v); check("R9 reading ro", v, 8'h29);
        wr(STAT, 8'hFF);
        rd(STAT, v); check("R9 status ro", v, 8'h00);
        check("R9 alert", {7'd0, alert}, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule